// File: doc/BRIEF.md
# SDRAM Chip-Select Window Decoder

This block places up to four SDRAM chip selects in a 36-bit physical address space. Software programs each chip select through a pair of 32-bit registers: one holds the window base and the other holds the window size and an enable bit. A lookup port takes an address and, one clock later, returns the chip select that contains it, the byte offset inside that window and an attribute code derived from the chip-select index. If no enabled window contains the address, the block raises a miss.

The block also presents a packed list of the enabled windows that sit wholly below the 4 GB line. The list holds the chip-select index, the 32-bit base, the size in 16 MB units and the attribute of each such window, together with the number of valid entries. Other bus masters read this list to set up their own routes to memory. The list is combinational from the register contents, so it tracks every register write.

Top module: `dram_cs_decoder`

## Requirements
- R1: After reset every register reads zero, no window is enabled, every lookup misses and the export count is zero.
- R2: Word offset n×8 holds the base of window n (bits 31:24 give address bits 31:24, bits 3:0 give address bits 35:32). Offset n×8+4 holds its size register (bit 0 enable, bits 4:2 a chip-select tag, bits 31:24 size minus one in 16 MB units). Unimplemented bits read back as zero.
- R3: A lookup presented with `lk_valid` in one cycle gives `res_valid` in the next cycle, and in no other cycle.
- R4: Window n spans from base to base + (size field + 1) × 16 MB, with the low end inclusive and the high end exclusive. On a hit, `res_offset` equals the address minus the window base.
- R5: When several enabled windows contain the address, the window with the lowest index wins.
- R6: A lookup that no enabled window contains sets `res_miss` and clears `res_hit`. Disabled windows never match. `res_hit` and `res_miss` are never high together, and one of them is high exactly when `res_valid` is high.
- R7: The attribute of chip select i is 0xF with bit i cleared in bits 3:0. Bit 4 equals the `COHERENT_ATTR` parameter, which defaults to 0.
- R8: The export list holds only windows that are enabled and have zero in bits 35:32 of their base. The entries are packed from slot 0 in ascending chip-select order, `exp_count` gives their number, and unused slots read all zero.
- R9: The export list and count reflect a register write from the cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (byte offset bits 4:2) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at `reg_addr` |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 36 | Lookup physical address |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Address falls inside an enabled window |
| res_miss | output | 1 | Address matches no enabled window |
| res_cs | output | 2 | Winning chip-select index |
| res_offset | output | 36 | Offset of the address inside the winning window |
| res_attr | output | 5 | Attribute code of the winning chip select |
| exp_count | output | 3 | Number of valid export entries |
| exp_cs | output | 4×2 | Chip-select index for each export slot |
| exp_base | output | 4×32 | Base address for each export slot |
| exp_units | output | 4×9 | Size in 16 MB units for each export slot |
| exp_attr | output | 4×5 | Attribute for each export slot |

## Verification
The hardest cases to reach are the ones where window ordering matters. In one, two enabled windows overlap and only the lower index may answer. In another, a window that still decodes has high base bits set, so it has to disappear from the export list and the later entries have to move down. The stimulus first programs a window with every writable bit set. That gives it a 4 GB span and a nonzero high base, and its decode and its absence from the list are both checked. The same window is then moved below 4 GB so that it overlaps another, and the lowest window is disabled to force the list to compact again. Lookups at the first and last byte of each window, and one byte past the end, pin down the range bounds.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam int UNIT_LSB = 24;
  localparam int HI_W     = 4;
  localparam int FLD_W    = 8;

  typedef struct packed {
    logic             en;
    logic [2:0]       tag;
    logic [FLD_W-1:0] szm;
    logic [FLD_W-1:0] base_lo;
    logic [HI_W-1:0]  base_hi;
  } dcd_win_t;

  function automatic logic [4:0] cs_attr(input int unsigned idx, input bit coh);
    logic [3:0] m;
    m = 4'hF;
    m[idx[1:0]] = 1'b0;
    return {coh, m};
  endfunction
endpackage

// File: rtl/dcd_rst_sync.sv
module dcd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/dcd_regfile.sv
module dcd_regfile
  import dcd_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int REG_AW = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_AW-1:2]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output dcd_win_t [NUM_CS-1:0] wins
);
  localparam int SEL_W = REG_AW - 3;

  dcd_win_t [NUM_CS-1:0] win_q, win_d;
  logic [SEL_W-1:0] sel;
  logic             is_size;

  assign sel     = addr[REG_AW-1:3];
  assign is_size = addr[2];

  always_comb begin
    win_d = win_q;
    for (int i = 0; i < NUM_CS; i++) begin
      if (sel == SEL_W'(i)) begin
        if (is_size) begin
          win_d[i].en  = wdata[0];
          win_d[i].tag = wdata[4:2];
          win_d[i].szm = wdata[31:UNIT_LSB];
        end else begin
          win_d[i].base_lo = wdata[31:UNIT_LSB];
          win_d[i].base_hi = wdata[HI_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     win_q <= '0;
    else if (wr_en) win_q <= win_d;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (sel == SEL_W'(i)) begin
        if (is_size) begin
          rdata[0]              = win_q[i].en;
          rdata[4:2]            = win_q[i].tag;
          rdata[31:UNIT_LSB]    = win_q[i].szm;
        end else begin
          rdata[31:UNIT_LSB]    = win_q[i].base_lo;
          rdata[HI_W-1:0]       = win_q[i].base_hi;
        end
      end
    end
  end

  assign wins = win_q;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_chk
    // R2
    enable_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_W'(g) && is_size) |=> (wins[g].en == $past(wdata[0])));
    // R2
    base_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_W'(g) && !is_size) |=> (wins[g].base_lo == $past(wdata[31:24])));
  end
endmodule

// File: rtl/dcd_win_match.sv
module dcd_win_match
  import dcd_pkg::*;
#(
  parameter int IDX           = 0,
  parameter bit COHERENT_ATTR = 1'b0,
  parameter int ADDR_W        = 36
) (
  input  dcd_win_t          win,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] offset,
  output logic [4:0]        attr
);
  logic [ADDR_W-1:0] base_full;
  logic [ADDR_W:0]   span;
  logic [ADDR_W:0]   top_excl;

  always_comb begin
    base_full = '0;
    base_full[ADDR_W-1:32]       = win.base_hi;
    base_full[31:UNIT_LSB]       = win.base_lo;
    span     = (ADDR_W+1)'({1'b0, win.szm} + 9'd1) << UNIT_LSB;
    top_excl = {1'b0, base_full} + span;
    hit      = win.en && (addr >= base_full) && ({1'b0, addr} < top_excl);
    offset   = addr - base_full;
    attr     = cs_attr(IDX, COHERENT_ATTR);
  end
endmodule

// File: rtl/dcd_export_pack.sv
module dcd_export_pack
  import dcd_pkg::*;
#(
  parameter int NUM_CS        = 4,
  parameter bit COHERENT_ATTR = 1'b0,
  localparam int CS_W  = $clog2(NUM_CS),
  localparam int CNT_W = $clog2(NUM_CS + 1)
) (
  input  dcd_win_t [NUM_CS-1:0]          wins,
  output logic [CNT_W-1:0]               count,
  output logic [NUM_CS-1:0][CS_W-1:0]    e_cs,
  output logic [NUM_CS-1:0][31:0]        e_base,
  output logic [NUM_CS-1:0][FLD_W:0]     e_units,
  output logic [NUM_CS-1:0][4:0]         e_attr
);
  always_comb begin
    int slot;
    slot    = 0;
    e_cs    = '0;
    e_base  = '0;
    e_units = '0;
    e_attr  = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (wins[i].en && (wins[i].base_hi == '0)) begin
        e_cs[slot]    = CS_W'(i);
        e_base[slot]  = {wins[i].base_lo, {UNIT_LSB{1'b0}}};
        e_units[slot] = {1'b0, wins[i].szm} + 1'b1;
        e_attr[slot]  = cs_attr(i, COHERENT_ATTR);
        slot = slot + 1;
      end
    end
    count = CNT_W'(slot);
  end
endmodule

// File: rtl/dram_cs_decoder.sv
module dram_cs_decoder
  import dcd_pkg::*;
#(
  parameter int NUM_CS        = 4,
  parameter bit COHERENT_ATTR = 1'b0,
  localparam int REG_AW = $clog2(NUM_CS * 8),
  localparam int ADDR_W = 32 + HI_W,
  localparam int CS_W   = $clog2(NUM_CS),
  localparam int CNT_W  = $clog2(NUM_CS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr_en,
  input  logic [REG_AW-1:2]             reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  input  logic                          lk_valid,
  input  logic [ADDR_W-1:0]             lk_addr,
  output logic                          res_valid,
  output logic                          res_hit,
  output logic                          res_miss,
  output logic [CS_W-1:0]               res_cs,
  output logic [ADDR_W-1:0]             res_offset,
  output logic [4:0]                    res_attr,
  output logic [CNT_W-1:0]              exp_count,
  output logic [NUM_CS-1:0][CS_W-1:0]   exp_cs,
  output logic [NUM_CS-1:0][31:0]       exp_base,
  output logic [NUM_CS-1:0][FLD_W:0]    exp_units,
  output logic [NUM_CS-1:0][4:0]        exp_attr
);
  logic srst_n;
  dcd_win_t [NUM_CS-1:0] wins;

  dcd_rst_sync u_rst_sync (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  dcd_regfile #(.NUM_CS(NUM_CS), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .wins(wins)
  );

  logic [NUM_CS-1:0]             hit_v;
  logic [NUM_CS-1:0][ADDR_W-1:0] off_v;
  logic [NUM_CS-1:0][4:0]        attr_v;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_match
    dcd_win_match #(.IDX(g), .COHERENT_ATTR(COHERENT_ATTR), .ADDR_W(ADDR_W)) u_match (
      .win(wins[g]), .addr(lk_addr), .hit(hit_v[g]), .offset(off_v[g]), .attr(attr_v[g])
    );
  end

  dcd_export_pack #(.NUM_CS(NUM_CS), .COHERENT_ATTR(COHERENT_ATTR)) u_pack (
    .wins(wins), .count(exp_count), .e_cs(exp_cs), .e_base(exp_base),
    .e_units(exp_units), .e_attr(exp_attr)
  );

  // lowest index wins: scan downward so the last assignment is the smallest index
  logic              sel_hit;
  logic [CS_W-1:0]   sel_cs;
  logic [ADDR_W-1:0] sel_off;
  logic [4:0]        sel_attr;

  always_comb begin
    sel_hit  = 1'b0;
    sel_cs   = '0;
    sel_off  = '0;
    sel_attr = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        sel_hit  = 1'b1;
        sel_cs   = CS_W'(i);
        sel_off  = off_v[i];
        sel_attr = attr_v[i];
      end
    end
  end

  logic              valid_d, hit_d, miss_d;
  logic              valid_q, hit_q, miss_q;
  logic [CS_W-1:0]   cs_q;
  logic [ADDR_W-1:0] off_q;
  logic [4:0]        attr_q;

  always_comb begin
    valid_d = lk_valid;
    hit_d   = lk_valid && sel_hit;
    miss_d  = lk_valid && !sel_hit;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      hit_q   <= hit_d;
      miss_q  <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cs_q   <= '0;
      off_q  <= '0;
      attr_q <= '0;
    end else if (lk_valid) begin
      cs_q   <= sel_cs;
      off_q  <= sel_off;
      attr_q <= sel_attr;
    end
  end

  assign res_valid  = valid_q;
  assign res_hit    = hit_q;
  assign res_miss   = miss_q;
  assign res_cs     = cs_q;
  assign res_offset = off_q;
  assign res_attr   = attr_q;

  // R3
  lookup_latency_chk: assert property (@(posedge clk) disable iff (!srst_n)
    lk_valid |=> res_valid);
  // R3
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !lk_valid |=> !res_valid);
  // R6
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(res_hit && res_miss));
  // R6
  result_kind_chk: assert property (@(posedge clk) disable iff (!srst_n)
    res_valid == (res_hit || res_miss));
  // R7
  attr_code_chk: assert property (@(posedge clk) disable iff (!srst_n)
    res_hit |-> ($countones(res_attr[3:0]) == 3 && !res_attr[res_cs] && res_attr[4] == COHERENT_ATTR));
  // R4
  offset_span_chk: assert property (@(posedge clk) disable iff (!srst_n)
    res_hit |-> (res_offset[ADDR_W-1:32] == '0));
  // R8
  export_count_chk: assert property (@(posedge clk) disable iff (!srst_n)
    exp_count <= CNT_W'(NUM_CS));
  // R8
  export_head_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (exp_count != '0) |-> (exp_units[0] != '0 && $countones(exp_attr[0][3:0]) == 3));
endmodule

// File: tb/dram_cs_decoder_tb_top.sv
module dram_cs_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 4;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr_en;
  logic [4:2] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic lk_valid;
  logic [35:0] lk_addr;
  logic res_valid, res_hit, res_miss;
  logic [1:0] res_cs;
  logic [35:0] res_offset;
  logic [4:0] res_attr;
  logic [2:0] exp_count;
  logic [NCS-1:0][1:0] exp_cs;
  logic [NCS-1:0][31:0] exp_base;
  logic [NCS-1:0][8:0] exp_units;
  logic [NCS-1:0][4:0] exp_attr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cs_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss), .res_cs(res_cs),
    .res_offset(res_offset), .res_attr(res_attr), .exp_count(exp_count), .exp_cs(exp_cs),
    .exp_base(exp_base), .exp_units(exp_units), .exp_attr(exp_attr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the programmed windows
  bit        m_en [NCS];
  bit [2:0]  m_tag [NCS];
  bit [7:0]  m_szm [NCS];
  bit [7:0]  m_lo [NCS];
  bit [3:0]  m_hi [NCS];

  typedef struct {
    bit        hit;
    bit [1:0]  cs;
    bit [35:0] off;
    bit [4:0]  attr;
    string     tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic check(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [4:0] attr_of(input int i);
    bit [4:0] a;
    a = 5'h0F;
    a[i] = 1'b0;
    return a;
  endfunction

  function automatic exp_t model_lookup(input bit [35:0] a, input string tag);
    exp_t e;
    e.hit = 0; e.cs = 0; e.off = 0; e.attr = 0; e.tag = tag;
    for (int i = NCS - 1; i >= 0; i--) begin
      bit [36:0] b, t;
      b = {1'b0, m_hi[i], m_lo[i], 24'h0};
      t = b + (37'(m_szm[i]) + 37'd1) * 37'h1000000;
      if (m_en[i] && {1'b0, a} >= b && {1'b0, a} < t) begin
        e.hit = 1; e.cs = 2'(i); e.off = 36'({1'b0, a} - b); e.attr = attr_of(i);
      end
    end
    return e;
  endfunction

  task automatic reg_write(input bit [4:0] byte_off, input bit [31:0] d);
    int n;
    @(negedge clk);
    reg_wr_en = 1; reg_addr = byte_off[4:2]; reg_wdata = d;
    n = byte_off[4:3];
    if (byte_off[2]) begin m_en[n] = d[0]; m_tag[n] = d[4:2]; m_szm[n] = d[31:24]; end
    else begin m_lo[n] = d[31:24]; m_hi[n] = d[3:0]; end
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic reg_check(input bit [4:0] byte_off, input bit [31:0] expv, input string req);
    @(negedge clk);
    reg_addr = byte_off[4:2];
    #1;
    check(req, reg_rdata === expv, 64'(reg_rdata), 64'(expv));
  endtask

  task automatic lookup(input bit [35:0] a, input string tag);
    @(negedge clk);
    sb_q.push_back(model_lookup(a, tag));
    lk_valid = 1; lk_addr = a;
  endtask

  task automatic lookup_end();
    @(negedge clk);
    lk_valid = 0;
    repeat (2) @(negedge clk);
    check("R3 drain", sb_q.size() == 0, 64'(sb_q.size()), 64'd0);
  endtask

  // compares the export list against the bench model (R8, R9)
  task automatic export_check(input string req);
    int slot;
    slot = 0;
    #1;
    for (int i = 0; i < NCS; i++) begin
      if (m_en[i] && m_hi[i] == 0) begin
        check({req, " slot cs"}, exp_cs[slot] === 2'(i), 64'(exp_cs[slot]), 64'(i));
        check({req, " slot base"}, exp_base[slot] === {m_lo[i], 24'h0}, 64'(exp_base[slot]), 64'({m_lo[i], 24'h0}));
        check({req, " slot units"}, exp_units[slot] === 9'(m_szm[i]) + 9'd1, 64'(exp_units[slot]), 64'(9'(m_szm[i]) + 9'd1));
        check({req, " slot attr"}, exp_attr[slot] === attr_of(i), 64'(exp_attr[slot]), 64'(attr_of(i)));
        slot++;
      end
    end
    check({req, " count"}, exp_count === 3'(slot), 64'(exp_count), 64'(slot));
    for (int k = slot; k < NCS; k++)
      check({req, " unused slot zero"},
            exp_cs[k] === 0 && exp_base[k] === 0 && exp_units[k] === 0 && exp_attr[k] === 0,
            64'(exp_units[k]), 64'd0);
  endtask

  // monitor: pops one expected item per result
  initial begin
    forever begin
      @(negedge clk);
      if (res_valid === 1'b1) begin
        if (sb_q.size() == 0) begin
          check("R3 unexpected result", 1'b0, 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check({e.tag, " hit"}, res_hit === e.hit, 64'(res_hit), 64'(e.hit));
          check({"R6 ", e.tag, " miss"}, res_miss === !e.hit, 64'(res_miss), 64'(!e.hit));
          if (e.hit) begin
            check({e.tag, " cs"}, res_cs === e.cs, 64'(res_cs), 64'(e.cs));
            check({e.tag, " offset"}, res_offset === e.off, 64'(res_offset), 64'(e.off));
            check({"R7 ", e.tag, " attr"}, res_attr === e.attr, 64'(res_attr), 64'(e.attr));
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; reg_wr_en = 0; reg_addr = 0; reg_wdata = 0; lk_valid = 0; lk_addr = 0;
    for (int i = 0; i < NCS; i++) begin m_en[i] = 0; m_tag[i] = 0; m_szm[i] = 0; m_lo[i] = 0; m_hi[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int r = 0; r < 8; r++) reg_check(5'(r * 4), 32'h0, "R1 reset readback");
    export_check("R1 reset export");
    lookup(36'h0_0000_0000, "R1 reset lookup");
    lookup(36'h0_8000_0000, "R1 reset lookup");
    lookup_end();

    // program windows
    reg_write(5'h00, 32'h0000_0000);
    reg_write(5'h04, 32'h0F00_0001);   // cs0 256 MB at 0
    reg_write(5'h08, 32'h1000_0000);
    reg_write(5'h0C, 32'h0000_0005);   // cs1 16 MB at 0x10000000
    reg_write(5'h10, 32'h2000_0001);
    reg_write(5'h14, 32'h0F00_0009);   // cs2 256 MB at 0x1_20000000
    reg_write(5'h18, 32'h4000_0000);
    reg_write(5'h1C, 32'h0F00_000C);   // cs3 disabled
    export_check("R8 first layout");
    reg_check(5'h0C, 32'h0000_0005, "R2 size readback");
    reg_check(5'h10, 32'h2000_0001, "R2 base readback");

    lookup(36'h0_0000_0000, "R4 cs0 low edge");
    lookup(36'h0_0FFF_FFFF, "R4 cs0 high edge");
    lookup(36'h0_1000_0000, "R4 cs1 low edge");
    lookup(36'h0_10FF_FFFF, "R4 cs1 high edge");
    lookup(36'h0_1100_0000, "R4 one past cs1");
    lookup(36'h1_2000_0010, "R4 cs2 high base");
    lookup(36'h0_4000_0000, "R6 disabled cs3");
    lookup_end();

    // all writable bits: high base and 4 GB span
    reg_write(5'h18, 32'hFFFF_FFFF);
    reg_write(5'h1C, 32'hFFFF_FFFF);
    reg_check(5'h18, 32'hFF00_000F, "R2 base masked readback");
    reg_check(5'h1C, 32'hFF00_001D, "R2 size masked readback");
    export_check("R8 high base excluded");
    lookup(36'hF_FF00_0000, "R4 cs3 high decode");
    lookup(36'hF_FFFF_FFFF, "R4 cs3 top byte");
    lookup_end();

    // move cs3 below 4 GB, overlapping cs2
    reg_write(5'h18, 32'h4000_0000);
    export_check("R9 list after base write");
    lookup(36'h0_FFFF_FFFF, "R4 cs3 mid");
    lookup(36'h1_3FFF_FFFF, "R4 cs3 end");
    lookup(36'h1_2000_0000, "R5 overlap cs2 over cs3");
    lookup(36'h1_4000_0000, "R6 past cs3");
    lookup_end();

    // disable cs0: list compacts
    reg_write(5'h04, 32'h0F00_0000);
    export_check("R9 list after disable");
    lookup(36'h0_0000_0100, "R6 disabled cs0");
    lookup_end();

    done = 1;
    finish_run();
  end
endmodule